// File: doc/BRIEF.md
# Transmit descriptor chain DMA

This block walks a linked list of transmit descriptors held in memory and streams the frame that each descriptor points at onto a byte stream. A descriptor is three little-endian 32-bit words. The word at offset 0 is the buffer address, offset 4 holds the size word and offset 8 holds the address of the next descriptor. In the size word, bit 31 is the empty flag and bits 10:0 are the frame length in bytes. Software loads a descriptor base address and then writes the enable bit of the control register. If the transmit enable input is high, the engine starts at the base descriptor and sends every descriptor that is not empty. It hands each one back by setting the empty flag and follows the next pointers until it reaches an empty descriptor. It then reports an underrun and clears its own enable bit.

Frames leave on one of two valid/ready byte ports, each with a last marker. The transmit port is used normally. The loopback port is used when the loopback input is high. All memory traffic goes through a single 32-bit master that carries one word access at a time with a request/acknowledge handshake. Packet-sent and underrun are one-cycle event pulses for a separate status block.

Top module: `tx_chain_dma`

## Requirements
- R1: After reset, busy, ctl_en, mem_req, tx_valid, lb_valid and both event outputs are low, and base_addr reads 0.
- R2: A base register write stores base_wdata with bits 1:0 forced to zero, and base_addr shows the stored value.
- R3: A control write with ctl_wdata=1 while idle starts a walk at the base descriptor only if cfg_tx_en is high. With cfg_tx_en low, no memory access occurs, busy stays low and ctl_en reads 1.
- R4: For each descriptor the size word (descriptor+4) is read first. If its bit 31 is set, no other word of that descriptor is read. Otherwise the buffer address (+0) and the next pointer (+8) are read.
- R5: A frame is sent as the first L bytes starting at the buffer address with bits 1:0 ignored, where L is size-word bits 10:0. Byte k comes from bits 8*(k mod 4)+7 : 8*(k mod 4) of memory word k/4, so the byte order is little-endian. Only the final byte carries last. A frame of length 0 emits no bytes.
- R6: After a frame, the size word at descriptor+4 is written back with bit 31 set and all other bits unchanged. evt_pkt_sent pulses for one cycle right after that write is acknowledged. The walk then continues at the next pointer with bits 1:0 ignored.
- R7: On reaching a descriptor with the empty flag set, evt_underrun pulses once, busy drops in the same cycle, ctl_en is cleared and no write-back is made.
- R8: The loopback input is sampled when a descriptor's size word is accepted. When it is high, that frame's bytes appear only on the lb_* port; otherwise they appear only on the tx_* port. The two valid outputs are never high together.
- R9: A memory request holds its address, direction and write data until acknowledged, and only one access is outstanding. A stream byte holds its data and last marker while its ready is low.
- R10: When a base write and a starting control write fall in the same cycle, the walk starts from the newly written base address.
- R11: A control write made while busy is ignored: ctl_en keeps its value and the walk runs to its normal end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 1 | Value written to the DMA enable bit |
| base_wr | input | 1 | Descriptor base register write strobe |
| base_wdata | input | 32 | Descriptor base value written |
| cfg_tx_en | input | 1 | Transmit enable from configuration register 1, bit 0 |
| cfg_loopback | input | 1 | Loopback select from configuration register 1, bit 8 |
| ctl_en | output | 1 | Current DMA enable bit |
| base_addr | output | 32 | Current descriptor base register |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete (read data valid) |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Transmit path accepts byte |
| lb_valid | output | 1 | Loopback byte valid |
| lb_data | output | 8 | Loopback byte |
| lb_last | output | 1 | Final byte of frame |
| lb_ready | input | 1 | Receive path accepts byte |
| evt_pkt_sent | output | 1 | One-cycle pulse per frame handed back |
| evt_underrun | output | 1 | One-cycle pulse when the walk meets an empty descriptor |

## Verification
The two functions that can meet in one cycle are a base register write and the start of a walk. The bench drives both strobes on the same clock while the old base points at an already empty descriptor. A design that started from the stale base would emit no frame and make no write-back. The expected result is one full frame plus one write-back at the new chain. A second collision, a control write that arrives mid-walk, is provoked under stream backpressure and judged by ctl_en staying 1 and the frame completing intact.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  localparam int WORD_W     = 32;
  localparam int LANES      = WORD_W / 8;
  localparam int LANE_CNT_W = $clog2(LANES) + 1;
  localparam int LEN_W      = 11;
  localparam int EMPTY_BIT  = 31;
  localparam int OFS_BUF    = 0;
  localparam int OFS_SIZE   = 4;
  localparam int OFS_NEXT   = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SIZE, ST_BUF, ST_NEXT, ST_DATA, ST_EMIT, ST_WB
  } walk_st_e;

  function automatic logic [WORD_W-1:0] word_align(input logic [WORD_W-1:0] a);
    return {a[WORD_W-1:2], 2'b00};
  endfunction

  function automatic logic [LANE_CNT_W-1:0] beat_bytes(input logic [LEN_W-1:0] rem);
    if (rem >= LEN_W'(LANES)) return LANE_CNT_W'(LANES);
    return LANE_CNT_W'(rem);
  endfunction

  function automatic logic [WORD_W-1:0] mark_empty(input logic [WORD_W-1:0] sw);
    return sw | (WORD_W'(1) << EMPTY_BIT);
  endfunction
endpackage

// File: rtl/tcd_ctrl.sv
module tcd_ctrl
  import tcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_wdata,
  input  logic              base_wr,
  input  logic [WORD_W-1:0] base_wdata,
  input  logic              cfg_tx_en,
  input  logic              walk_busy,
  input  logic              walk_underrun,
  output logic              ctl_en,
  output logic [WORD_W-1:0] base_q,
  output logic              start,
  output logic [WORD_W-1:0] start_addr
);
  logic ctl_take;

  assign ctl_take   = ctl_wr && !walk_busy;
  assign start      = ctl_take && ctl_wdata && cfg_tx_en;
  assign start_addr = base_wr ? word_align(base_wdata) : base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      base_q <= '0;
    end else begin
      if (base_wr) base_q <= word_align(base_wdata);
      if (ctl_take) ctl_en <= ctl_wdata;
      else if (walk_underrun) ctl_en <= 1'b0;
    end
  end
endmodule

// File: rtl/tcd_serializer.sv
module tcd_serializer
  import tcd_pkg::*;
#(
  parameter int NLANES = LANES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [8*NLANES-1:0]   word,
  input  logic [LANE_CNT_W-1:0] nbytes,
  input  logic                  last_word,
  output logic                  out_valid,
  output logic [7:0]            out_data,
  output logic                  out_last,
  input  logic                  out_ready,
  output logic                  done
);
  localparam int IDX_W = $clog2(NLANES);

  logic [8*NLANES-1:0]   word_q;
  logic [IDX_W-1:0]      idx_q;
  logic [LANE_CNT_W-1:0] cnt_q;
  logic                  lastw_q;
  logic                  full_q;
  logic                  final_b;

  assign final_b   = (LANE_CNT_W'(idx_q) + LANE_CNT_W'(1)) == cnt_q;
  assign out_valid = full_q;
  assign out_data  = 8'(word_q >> {idx_q, 3'b000});
  assign out_last  = full_q && lastw_q && final_b;
  assign done      = full_q && out_ready && final_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      lastw_q <= 1'b0;
      full_q  <= 1'b0;
    end else if (load) begin
      word_q  <= word;
      idx_q   <= '0;
      cnt_q   <= nbytes;
      lastw_q <= last_word;
      full_q  <= 1'b1;
    end else if (full_q && out_ready) begin
      if (final_b) full_q <= 1'b0;
      else idx_q <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/tcd_port_mux.sv
module tcd_port_mux (
  input  logic       sel_lb,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last,
  input  logic       tx_ready,
  output logic       lb_valid,
  output logic [7:0] lb_data,
  output logic       lb_last,
  input  logic       lb_ready
);
  assign tx_valid = in_valid && !sel_lb;
  assign lb_valid = in_valid && sel_lb;
  assign tx_data  = in_data;
  assign lb_data  = in_data;
  assign tx_last  = in_last && !sel_lb;
  assign lb_last  = in_last && sel_lb;
  assign in_ready = sel_lb ? lb_ready : tx_ready;
endmodule

// File: rtl/tcd_walker.sv
module tcd_walker
  import tcd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [WORD_W-1:0]     start_addr,
  input  logic                  loop_in,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [WORD_W-1:0]     mem_addr,
  output logic [WORD_W-1:0]     mem_wdata,
  input  logic                  mem_ack,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic                  ser_load,
  output logic [WORD_W-1:0]     ser_word,
  output logic [LANE_CNT_W-1:0] ser_nbytes,
  output logic                  ser_last,
  input  logic                  ser_done,
  output logic                  busy,
  output logic                  loop_sel,
  output logic                  sent_pulse,
  output logic                  underrun_pulse
);
  walk_st_e          st;
  logic [WORD_W-1:0] desc_q, size_q, buf_q, next_q;
  logic [LEN_W-1:0]  rem_q;
  logic [WORD_W-1:0] raw_addr;

  always_comb begin
    case (st)
      ST_SIZE: raw_addr = desc_q + WORD_W'(OFS_SIZE);
      ST_BUF:  raw_addr = desc_q + WORD_W'(OFS_BUF);
      ST_NEXT: raw_addr = desc_q + WORD_W'(OFS_NEXT);
      ST_DATA: raw_addr = buf_q;
      ST_WB:   raw_addr = desc_q + WORD_W'(OFS_SIZE);
      default: raw_addr = desc_q;
    endcase
  end

  assign mem_req    = st inside {ST_SIZE, ST_BUF, ST_NEXT, ST_DATA, ST_WB};
  assign mem_we     = (st == ST_WB);
  assign mem_addr   = word_align(raw_addr);
  assign mem_wdata  = mark_empty(size_q);
  assign ser_load   = (st == ST_DATA) && mem_ack;
  assign ser_word   = mem_rdata;
  assign ser_nbytes = beat_bytes(rem_q);
  assign ser_last   = rem_q <= LEN_W'(LANES);
  assign busy       = (st != ST_IDLE);
  assign loop_sel   = loop_q;

  logic loop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= ST_IDLE;
      desc_q         <= '0;
      size_q         <= '0;
      buf_q          <= '0;
      next_q         <= '0;
      rem_q          <= '0;
      loop_q         <= 1'b0;
      sent_pulse     <= 1'b0;
      underrun_pulse <= 1'b0;
    end else begin
      sent_pulse     <= 1'b0;
      underrun_pulse <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          desc_q <= word_align(start_addr);
          st     <= ST_SIZE;
        end
        ST_SIZE: if (mem_ack) begin
          size_q <= mem_rdata;
          if (mem_rdata[EMPTY_BIT]) begin
            underrun_pulse <= 1'b1;
            st             <= ST_IDLE;
          end else begin
            loop_q <= loop_in;
            rem_q  <= mem_rdata[LEN_W-1:0];
            st     <= ST_BUF;
          end
        end
        ST_BUF: if (mem_ack) begin
          buf_q <= word_align(mem_rdata);
          st    <= ST_NEXT;
        end
        ST_NEXT: if (mem_ack) begin
          next_q <= mem_rdata;
          st     <= (rem_q == '0) ? ST_WB : ST_DATA;
        end
        ST_DATA: if (mem_ack) begin
          rem_q <= rem_q - LEN_W'(beat_bytes(rem_q));
          buf_q <= buf_q + WORD_W'(LANES);
          st    <= ST_EMIT;
        end
        ST_EMIT: if (ser_done) begin
          st <= (rem_q == '0) ? ST_WB : ST_DATA;
        end
        ST_WB: if (mem_ack) begin
          sent_pulse <= 1'b1;
          desc_q     <= word_align(next_q);
          st         <= ST_SIZE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_chain_dma.sv
module tx_chain_dma
  import tcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_wdata,
  input  logic              base_wr,
  input  logic [WORD_W-1:0] base_wdata,
  input  logic              cfg_tx_en,
  input  logic              cfg_loopback,
  output logic              ctl_en,
  output logic [WORD_W-1:0] base_addr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              lb_valid,
  output logic [7:0]        lb_data,
  output logic              lb_last,
  input  logic              lb_ready,
  output logic              evt_pkt_sent,
  output logic              evt_underrun
);
  logic                  start;
  logic [WORD_W-1:0]     start_addr;
  logic                  ser_load, ser_last, ser_done;
  logic [WORD_W-1:0]     ser_word;
  logic [LANE_CNT_W-1:0] ser_nbytes;
  logic                  loop_sel;
  logic                  s_valid, s_last, s_ready;
  logic [7:0]            s_data;

  tcd_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .base_wr(base_wr), .base_wdata(base_wdata), .cfg_tx_en(cfg_tx_en),
    .walk_busy(busy), .walk_underrun(evt_underrun), .ctl_en(ctl_en),
    .base_q(base_addr), .start(start), .start_addr(start_addr)
  );

  tcd_walker i_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .loop_in(cfg_loopback), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .ser_load(ser_load), .ser_word(ser_word),
    .ser_nbytes(ser_nbytes), .ser_last(ser_last), .ser_done(ser_done),
    .busy(busy), .loop_sel(loop_sel), .sent_pulse(evt_pkt_sent),
    .underrun_pulse(evt_underrun)
  );

  tcd_serializer #(.NLANES(LANES)) i_ser (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .word(ser_word),
    .nbytes(ser_nbytes), .last_word(ser_last), .out_valid(s_valid),
    .out_data(s_data), .out_last(s_last), .out_ready(s_ready), .done(ser_done)
  );

  tcd_port_mux i_mux (
    .sel_lb(loop_sel), .in_valid(s_valid), .in_data(s_data), .in_last(s_last),
    .in_ready(s_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .lb_valid(lb_valid),
    .lb_data(lb_data), .lb_last(lb_last), .lb_ready(lb_ready)
  );
endmodule

// File: rtl/tcd_chk.sv
module tcd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic        cfg_tx_en,
  input logic        ctl_en,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        tx_ready,
  input logic        lb_valid,
  input logic [7:0]  lb_data,
  input logic        lb_last,
  input logic        lb_ready,
  input logic        evt_pkt_sent,
  input logic        evt_underrun
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !tx_valid && !lb_valid); // R1
  AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !cfg_tx_en && !busy |=> !busy); // R3
  AST_SENT_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pkt_sent |-> $past(mem_req && mem_ack && mem_we)); // R6
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_pkt_sent && evt_underrun)); // R6
  AST_UNDERRUN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_underrun && !ctl_wr |=> !ctl_en); // R7
  AST_UNDERRUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_underrun |-> !busy); // R7
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && lb_valid)); // R8
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
      && $stable(mem_wdata)); // R9
  AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R9
  AST_LB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid && !lb_ready |=> lb_valid && $stable(lb_data) && $stable(lb_last)); // R9
endmodule

bind tx_chain_dma tcd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .cfg_tx_en(cfg_tx_en),
  .ctl_en(ctl_en), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
  .tx_ready(tx_ready), .lb_valid(lb_valid), .lb_data(lb_data),
  .lb_last(lb_last), .lb_ready(lb_ready), .evt_pkt_sent(evt_pkt_sent),
  .evt_underrun(evt_underrun)
);

// File: tb/test_tx_chain_dma.sv
module test_tx_chain_dma;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0, ctl_wdata = 1'b0, base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        cfg_tx_en = 1'b0, cfg_loopback = 1'b0;
  logic        ctl_en, busy, mem_req, mem_we;
  logic [31:0] base_addr, mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid, tx_last, lb_valid, lb_last;
  logic [7:0]  tx_data, lb_data;
  logic        tx_ready = 1'b0, lb_ready = 1'b0;
  logic        evt_pkt_sent, evt_underrun;

  tx_chain_dma i_tx_chain_dma (.*);

  typedef struct { logic [7:0] b; logic last; logic lb; } xb_t;
  xb_t         exp_q[$];
  logic [31:0] expw_a[$], expw_d[$];
  logic [31:0] mem [0:255];
  int n_chk = 0, n_bad = 0, acc_cnt = 0, pkt_cnt = 0, und_cnt = 0;
  int wait_c = 0, cyc = 0;
  bit bp_on = 0, dly_on = 0, done = 0;
  logic [15:0] rng = 16'hACE1;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] get_byte(logic [31:0] a);
    return 8'(mem[a[9:2]] >> (8 * a[1:0]));
  endfunction

  // per-clock reference: memory responder, stream and write-back scoreboard
  always @(negedge clk) begin
    cyc++;
    rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
    if (!rst_n) begin
      mem_ack = 1'b0; wait_c = 0;
    end else begin
      tx_ready = bp_on ? (rng[0] | rng[3]) : 1'b1;
      lb_ready = bp_on ? rng[1] : 1'b1;
      if (mem_ack) begin
        mem_ack = 1'b0; wait_c = 0;
      end else if (mem_req) begin
        if (wait_c >= (dly_on ? int'(rng[5:4]) : 0)) begin
          mem_ack = 1'b1; acc_cnt++;
          if (mem_we) begin
            if (expw_a.size() == 0)
              check(0, "R6", "unexpected write", mem_addr, 32'hX);
            else begin
              check(mem_addr == expw_a[0], "R6", "write-back addr", mem_addr, expw_a[0]);
              check(mem_wdata == expw_d[0], "R6", "write-back data", mem_wdata, expw_d[0]);
              void'(expw_a.pop_front()); void'(expw_d.pop_front());
            end
            mem[mem_addr[9:2]] = mem_wdata;
          end else mem_rdata = mem[mem_addr[9:2]];
        end else wait_c++;
      end
      check(!(tx_valid && lb_valid), "R8", "both ports valid", {tx_valid, lb_valid}, 0);
      if ((tx_valid && tx_ready) || (lb_valid && lb_ready)) begin
        if (exp_q.size() == 0)
          check(0, "R5", "unexpected byte", tx_valid ? tx_data : lb_data, 32'hX);
        else begin
          check(lb_valid == exp_q[0].lb, "R8", "port select", lb_valid, exp_q[0].lb);
          check((tx_valid ? tx_data : lb_data) == exp_q[0].b, "R5", "byte",
                tx_valid ? tx_data : lb_data, exp_q[0].b);
          check((tx_valid ? tx_last : lb_last) == exp_q[0].last, "R5", "last",
                tx_valid ? tx_last : lb_last, exp_q[0].last);
          void'(exp_q.pop_front());
        end
      end
      if (evt_pkt_sent) pkt_cnt++;
      if (evt_underrun) und_cnt++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic put_desc(logic [31:0] d, logic [31:0] b, logic [31:0] sz, logic [31:0] nx);
    mem[d[9:2]] = b; mem[d[9:2] + 1] = sz; mem[d[9:2] + 2] = nx;
  endtask

  task automatic expect_frame(logic [31:0] d, logic [31:0] b, logic [31:0] sz, bit lb);
    int len = int'(sz[10:0]);
    for (int i = 0; i < len; i++) begin
      xb_t x;
      x.b = get_byte({b[31:2], 2'b00} + 32'(i)); x.last = (i == len - 1); x.lb = lb;
      exp_q.push_back(x);
    end
    expw_a.push_back(d + 4); expw_d.push_back(sz | 32'h8000_0000);
  endtask

  task automatic base_write(logic [31:0] a);
    @(negedge clk); base_wr = 1'b1; base_wdata = a;
    @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic ctl_write(logic v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    do begin @(negedge clk); k++; end while (busy && k < 20000);
    @(negedge clk);
  endtask

  task automatic walk_end(string req, int p0, int u0, int npkt);
    check(pkt_cnt - p0 == npkt, req, "packets sent", pkt_cnt - p0, npkt);
    check(und_cnt - u0 == 1, "R7", "underrun pulses", und_cnt - u0, 1);
    check(exp_q.size() == 0, req, "bytes left", exp_q.size(), 0);
    check(expw_a.size() == 0, "R6", "write-backs left", expw_a.size(), 0);
    check(ctl_en == 1'b0, "R7", "ctl_en after underrun", ctl_en, 0);
    check(busy == 1'b0, "R7", "busy after underrun", busy, 0);
  endtask

  initial begin
    int p0, u0, a0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 ^ (32'(i) * 32'h0103_0507);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !ctl_en && !mem_req, "R1", "busy/ctl_en/req", {busy, ctl_en, mem_req}, 0);
    check(!tx_valid && !lb_valid, "R1", "stream valid", {tx_valid, lb_valid}, 0);
    check(!evt_pkt_sent && !evt_underrun, "R1", "events", {evt_pkt_sent, evt_underrun}, 0);
    check(base_addr == 0, "R1", "base_addr", base_addr, 0);
    // R2 alignment
    base_write(32'h0000_0103);
    @(negedge clk);
    check(base_addr == 32'h100, "R2", "base aligned", base_addr, 32'h100);
    // R3 transmit enable off
    a0 = acc_cnt;
    ctl_write(1'b1);
    repeat (10) @(negedge clk);
    check(acc_cnt == a0, "R3", "accesses with tx off", acc_cnt - a0, 0);
    check(busy == 1'b0, "R3", "busy with tx off", busy, 0);
    check(ctl_en == 1'b1, "R3", "ctl_en holds", ctl_en, 1);
    ctl_write(1'b0);
    check(ctl_en == 1'b0, "R3", "ctl_en cleared", ctl_en, 0);
    // R4 R5 R6 R7 plain chain
    cfg_tx_en = 1'b1;
    put_desc(32'h000, 32'h200, 32'h0000_0005, 32'h010);
    put_desc(32'h010, 32'h240, 32'h0010_0008, 32'h020);
    put_desc(32'h020, 32'h260, 32'h0000_0001, 32'h030);
    put_desc(32'h030, 32'h0, 32'h8000_0000, 32'h0);
    expect_frame(32'h000, 32'h200, 32'h0000_0005, 0);
    expect_frame(32'h010, 32'h240, 32'h0010_0008, 0);
    expect_frame(32'h020, 32'h260, 32'h0000_0001, 0);
    p0 = pkt_cnt; u0 = und_cnt;
    base_write(32'h000); ctl_write(1'b1);
    wait_idle();
    walk_end("R4", p0, u0, 3);
    // R5 R9 backpressure, delays, unaligned buffer, zero length
    bp_on = 1; dly_on = 1;
    put_desc(32'h040, 32'h282, 32'h0000_0007, 32'h051);
    put_desc(32'h050, 32'h2A0, 32'h0000_0000, 32'h060);
    put_desc(32'h060, 32'h2C0, 32'h0000_000D, 32'h070);
    put_desc(32'h070, 32'h0, 32'h8000_0000, 32'h0);
    expect_frame(32'h040, 32'h282, 32'h0000_0007, 0);
    expect_frame(32'h050, 32'h2A0, 32'h0000_0000, 0);
    expect_frame(32'h060, 32'h2C0, 32'h0000_000D, 0);
    p0 = pkt_cnt; u0 = und_cnt;
    base_write(32'h040); ctl_write(1'b1);
    wait_idle();
    walk_end("R9", p0, u0, 3);
    // R8 loopback
    cfg_loopback = 1'b1;
    put_desc(32'h100, 32'h300, 32'h0000_0006, 32'h110);
    put_desc(32'h110, 32'h0, 32'h8000_0000, 32'h0);
    expect_frame(32'h100, 32'h300, 32'h0000_0006, 1);
    p0 = pkt_cnt; u0 = und_cnt;
    base_write(32'h100); ctl_write(1'b1);
    wait_idle();
    walk_end("R8", p0, u0, 1);
    cfg_loopback = 1'b0;
    // R10 base write and start in the same cycle
    put_desc(32'h080, 32'h0, 32'h8000_0000, 32'h0);
    put_desc(32'h0C0, 32'h320, 32'h0000_0003, 32'h0D0);
    put_desc(32'h0D0, 32'h0, 32'h8000_0000, 32'h0);
    base_write(32'h080);
    expect_frame(32'h0C0, 32'h320, 32'h0000_0003, 0);
    p0 = pkt_cnt; u0 = und_cnt;
    @(negedge clk); base_wr = 1'b1; base_wdata = 32'h0C0; ctl_wr = 1'b1; ctl_wdata = 1'b1;
    @(negedge clk); base_wr = 1'b0; ctl_wr = 1'b0;
    wait_idle();
    walk_end("R10", p0, u0, 1);
    // R11 control write while busy
    put_desc(32'h120, 32'h340, 32'h0000_0028, 32'h130);
    put_desc(32'h130, 32'h0, 32'h8000_0000, 32'h0);
    expect_frame(32'h120, 32'h340, 32'h0000_0028, 0);
    p0 = pkt_cnt; u0 = und_cnt;
    base_write(32'h120); ctl_write(1'b1);
    repeat (5) @(negedge clk);
    ctl_write(1'b0);
    check(ctl_en == 1'b1, "R11", "ctl_en after busy write", ctl_en, 1);
    check(busy == 1'b1, "R11", "walk continues", busy, 1);
    wait_idle();
    walk_end("R11", p0, u0, 1);
    // R4 handed-back descriptor: only the size word is read
    bp_on = 0; dly_on = 0;
    p0 = pkt_cnt; u0 = und_cnt; a0 = acc_cnt;
    base_write(32'h000); ctl_write(1'b1);
    wait_idle();
    check(acc_cnt - a0 == 1, "R4", "reads on empty start", acc_cnt - a0, 1);
    walk_end("R7", p0, u0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule